// File: doc/BRIEF.md
# Multi-channel ADC scan sequencer

This block is the digital control for a successive-approximation converter that scans a set of analog inputs. A configuration word chooses which of up to 19 inputs take part (one mask bit per input), which way the scan runs, and how sequences repeat: single, continuous or discontinuous. It also sets whether the next conversion waits for the previous result to be read, whether the converter is powered only while it works, and what happens to unread data when a new result lands. A start command arms the sequencer. Hardware trigger pulses then launch conversions, and a stop command aborts at any point.

Towards the converter the block holds a request level, a channel number and a sampling length in half clock cycles. The converter answers with an end-of-sampling pulse and a done pulse that carries a 12-bit result. The sequencer keeps the last result in a data register and reports a result-pending level, end-of-sampling and end-of-sequence pulses, and a sticky overrun flag.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `running`, `conv_req`, `eoc`, `ovr`, `eoseq` and `eosmp` are 0 and `dout` is 0. `conv_pwr` equals the inverse of `auto_off`.
- R2: A sequence converts exactly the channels whose `chan_mask` bit is 1. They run in ascending index order when `scan_down` is 0 and in descending order when it is 1.
- R3: `conv_smp` gives the sampling length in half cycles for `smp_code` 0 to 7: 3, 15, 27, 57, 83, 111, 143 and 479.
- R4: In single mode (`cont_mode` 0, `disc_mode` 0), one trigger converts the whole sequence. In the cycle after the last done, `eoseq` pulses for one cycle and `running` falls. Triggers after that start nothing until the next start command.
- R5: With `cont_mode` 1 and `disc_mode` 0, the sequence restarts from its first channel without a trigger, and `running` stays 1 after `eoseq`.
- R6: With both `cont_mode` and `disc_mode` at 1, the sequence behaves as discontinuous without a restart: after the last channel, `running` falls.
- R7: With `disc_mode` 1, each trigger converts exactly one channel, the next one in scan order, and the block then waits for the next trigger.
- R8: With `wait_mode` 1, no new request is issued after a conversion until `dr_rd` pulses. The request is then issued in the next cycle (or the block waits for a trigger in discontinuous mode).
- R9: A `hw_trig` pulse that arrives while a conversion is running or during the wait delay is dropped and is not remembered later.
- R10: A `stop_cmd` pulse drops `conv_req` and `running` by the next cycle. A done pulse from the aborted conversion does not change `dout` or `eoc`.
- R11: With `auto_off` 1, `conv_pwr` is 1 only while `conv_req` is 1. With `auto_off` 0, `conv_pwr` is always 1.
- R12: A result that completes while `eoc` is 1 and `dr_rd` is 0 sets `ovr`. With `ovr_mode` 0, `dout` keeps the old value; with `ovr_mode` 1, it takes the new one. `ovr_clr` clears `ovr`.
- R13: `eoc` rises in the cycle after each accepted done and falls in the cycle after `dr_rd`. `eosmp` pulses once for each conversion, in the cycle after `conv_smp_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_mask | input | NCH | One bit per channel that takes part in the scan |
| scan_down | input | 1 | 1 scans from high index to low |
| cont_mode | input | 1 | Restart the sequence automatically |
| disc_mode | input | 1 | One channel per trigger |
| wait_mode | input | 1 | Hold the next conversion until the result is read |
| auto_off | input | 1 | Power the converter only while converting |
| ovr_mode | input | 1 | 1 overwrites unread data |
| smp_code | input | 3 | Sampling-length selector |
| start_cmd | input | 1 | Arm pulse |
| stop_cmd | input | 1 | Abort pulse |
| hw_trig | input | 1 | Hardware trigger pulse |
| dr_rd | input | 1 | Data-register read strobe |
| ovr_clr | input | 1 | Clears the overrun flag |
| conv_pwr | output | 1 | Converter power enable |
| conv_req | output | 1 | Conversion request level |
| conv_ch | output | CHW | Channel being converted |
| conv_smp | output | 9 | Sampling length in half cycles |
| conv_smp_end | input | 1 | Converter finished sampling |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | DW | Converter result |
| dout | output | DW | Data register |
| running | output | 1 | Armed or converting |
| eosmp | output | 1 | End-of-sampling pulse |
| eoc | output | 1 | Result pending |
| eoseq | output | 1 | End-of-sequence pulse |
| ovr | output | 1 | Sticky overrun flag |

## Verification
A wrong channel pointer shows up as the wrong `conv_ch` on the next request, and so in the order the converter stub logs, one conversion after the error. A state register that leaves a phase too early shows up as a `conv_req` during a wait delay, or as an extra conversion after a dropped trigger, within one cycle. A wrong pending bit leads to a wrong `dout`/`ovr` pair at the following done.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NCH = 19,
  parameter int DW  = 12,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_mask,
  input  logic           scan_down,
  input  logic           cont_mode,
  input  logic           disc_mode,
  input  logic           wait_mode,
  input  logic           auto_off,
  input  logic           ovr_mode,
  input  logic [2:0]     smp_code,
  input  logic           start_cmd,
  input  logic           stop_cmd,
  input  logic           hw_trig,
  input  logic           dr_rd,
  input  logic           ovr_clr,
  output logic           conv_pwr,
  output logic           conv_req,
  output logic [CHW-1:0] conv_ch,
  output logic [8:0]     conv_smp,
  input  logic           conv_smp_end,
  input  logic           conv_done,
  input  logic [DW-1:0]  conv_data,
  output logic [DW-1:0]  dout,
  output logic           running,
  output logic           eosmp,
  output logic           eoc,
  output logic           eoseq,
  output logic           ovr
);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_TRIG = 2'd1, S_CONV = 2'd2, S_WAIT = 2'd3} st_t;

  st_t            st;
  logic [CHW-1:0] ptr, first_ch, nxt_ch;
  logic           has_nxt;
  logic           eff_cont;
  logic           keep_old;

  assign eff_cont = cont_mode & ~disc_mode;
  assign keep_old = eoc & ~dr_rd;
  assign running  = (st != S_IDLE);
  assign conv_req = (st == S_CONV);
  assign conv_pwr = ~auto_off | conv_req;
  assign conv_ch  = ptr;

  always_comb begin
    case (smp_code)
      3'd0:    conv_smp = 9'd3;
      3'd1:    conv_smp = 9'd15;
      3'd2:    conv_smp = 9'd27;
      3'd3:    conv_smp = 9'd57;
      3'd4:    conv_smp = 9'd83;
      3'd5:    conv_smp = 9'd111;
      3'd6:    conv_smp = 9'd143;
      default: conv_smp = 9'd479;
    endcase
  end

  always_comb begin
    first_ch = '0;
    nxt_ch   = '0;
    has_nxt  = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      int j;
      j = scan_down ? k : NCH - 1 - k;
      if (chan_mask[j]) begin
        first_ch = CHW'(j);
        if (scan_down ? (j < int'(ptr)) : (j > int'(ptr))) begin
          nxt_ch  = CHW'(j);
          has_nxt = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ptr   <= '0;
      dout  <= '0;
      eoc   <= 1'b0;
      ovr   <= 1'b0;
      eoseq <= 1'b0;
      eosmp <= 1'b0;
    end else begin
      eoseq <= 1'b0;
      eosmp <= 1'b0;
      if (dr_rd)   eoc <= 1'b0;
      if (ovr_clr) ovr <= 1'b0;
      if (stop_cmd) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (start_cmd && |chan_mask) begin
            st  <= S_TRIG;
            ptr <= first_ch;
          end
          S_TRIG: if (hw_trig) st <= S_CONV;
          S_CONV: begin
            if (conv_smp_end) eosmp <= 1'b1;
            if (conv_done) begin
              if (!keep_old || ovr_mode) dout <= conv_data;
              if (keep_old) ovr <= 1'b1;
              eoc   <= 1'b1;
              eoseq <= ~has_nxt;
              ptr   <= has_nxt ? nxt_ch : first_ch;
              if (!has_nxt && !eff_cont) st <= S_IDLE;
              else if (wait_mode)        st <= S_WAIT;
              else if (disc_mode)        st <= S_TRIG;
              else                       st <= S_CONV;
            end
          end
          default: if (dr_rd) st <= disc_mode ? S_TRIG : S_CONV;
        endcase
      end
    end
  end

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stop_cmd,
  input logic          conv_req,
  input logic          running,
  input logic          conv_pwr,
  input logic          auto_off,
  input logic          ovr_mode,
  input logic          eoc,
  input logic          dr_rd,
  input logic          conv_done,
  input logic          ovr,
  input logic [1:0]    st,
  input logic [DW-1:0] dout
);

  // R10
  stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> (!conv_req && !running));

  // R10
  stop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> $stable(dout));

  // R11
  power_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req || !auto_off) |-> conv_pwr);

  // R12
  keep_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_mode && eoc && !dr_rd) |=> $stable(dout));

  // R12
  ovr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(conv_done));

  // R13
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_rd && !conv_done) |=> !eoc);

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && !dr_rd) |=> !conv_req);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_cmd(stop_cmd), .conv_req(conv_req),
  .running(running), .conv_pwr(conv_pwr), .auto_off(auto_off),
  .ovr_mode(ovr_mode), .eoc(eoc), .dr_rd(dr_rd), .conv_done(conv_done),
  .ovr(ovr), .st(st), .dout(dout)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;
  localparam int NCH = 19, DW = 12, CHW = 5, LAT = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [NCH-1:0] chan_mask = '0;
  logic scan_down = 0, cont_mode = 0, disc_mode = 0, wait_mode = 0;
  logic auto_off = 0, ovr_mode = 0;
  logic [2:0] smp_code = '0;
  logic start_cmd = 0, stop_cmd = 0, hw_trig = 0, dr_rd = 0, ovr_clr = 0;
  logic conv_pwr, conv_req;
  logic [CHW-1:0] conv_ch;
  logic [8:0] conv_smp;
  logic conv_smp_end = 0, conv_done = 0;
  logic [DW-1:0] conv_data = '0;
  logic [DW-1:0] dout;
  logic running, eosmp, eoc, eoseq, ovr;

  adc_seq_ctrl u_dut (.*);

  int nchk = 0, nfail = 0;
  int nseen = 0, neosmp = 0, neoseq = 0, cnt = 0;
  logic [CHW-1:0] seen [0:1023];
  int exp_ch [0:31];
  int exp_n;

  function automatic logic [DW-1:0] dfun(input logic [CHW-1:0] ch);
    return DW'(ch * 37 + 11);
  endfunction

  function automatic int smp_exp(input int code);
    int t [0:7] = '{3, 15, 27, 57, 83, 111, 143, 479};
    return t[code];
  endfunction

  // converter stub and event counters
  always @(negedge clk) begin
    conv_smp_end = 1'b0;
    if (eosmp) neosmp++;
    if (eoseq) neoseq++;
    if (conv_done) begin
      conv_done = 1'b0;
      cnt = 0;
    end else if (conv_req) begin
      cnt++;
      if (cnt == 3) conv_smp_end = 1'b1;
      if (cnt == LAT) begin
        conv_done = 1'b1;
        conv_data = dfun(conv_ch);
        seen[nseen & 1023] = conv_ch;
        nseen++;
      end
    end else begin
      cnt = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic p_start(); @(negedge clk) start_cmd = 1; @(negedge clk) start_cmd = 0; endtask
  task automatic p_stop();  @(negedge clk) stop_cmd = 1;  @(negedge clk) stop_cmd = 0;  endtask
  task automatic p_trig();  @(negedge clk) hw_trig = 1;   @(negedge clk) hw_trig = 0;   endtask
  task automatic p_rd();    @(negedge clk) dr_rd = 1;     @(negedge clk) dr_rd = 0;     endtask
  task automatic p_oclr();  @(negedge clk) ovr_clr = 1;   @(negedge clk) ovr_clr = 0;   endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && running; i++) @(negedge clk);
  endtask

  task automatic build_exp(input logic [NCH-1:0] m, input logic dn);
    exp_n = 0;
    for (int i = 0; i < NCH; i++) begin
      int j;
      j = dn ? NCH - 1 - i : i;
      if (m[j]) begin exp_ch[exp_n] = j; exp_n++; end
    end
  endtask

  task automatic cfg(input logic [NCH-1:0] m, input logic dn, input logic c, input logic d,
                     input logic w, input logic a, input logic o);
    chan_mask = m; scan_down = dn; cont_mode = c; disc_mode = d;
    wait_mode = w; auto_off = a; ovr_mode = o;
    p_rd(); p_oclr();
  endtask

  task automatic run_single(input logic [NCH-1:0] m, input logic dn);
    int s0, e0, q0;
    cfg(m, dn, 0, 0, 0, 0, 1);
    build_exp(m, dn);
    s0 = nseen; e0 = neosmp; q0 = neoseq;
    p_start(); p_trig(); wait_idle(); wn(2);
    chk(nseen - s0 == exp_n, "R2 count", nseen - s0, exp_n);
    for (int k = 0; k < exp_n; k++)
      chk(int'(seen[(s0 + k) & 1023]) == exp_ch[k], "R2 order", int'(seen[(s0 + k) & 1023]), exp_ch[k]);
    chk(dout == dfun(CHW'(exp_ch[exp_n-1])), "R12 overwrite", dout, dfun(CHW'(exp_ch[exp_n-1])));
    chk(ovr == (exp_n > 1), "R12 flag", ovr, exp_n > 1);
    chk(neosmp - e0 == exp_n, "R13 eosmp", neosmp - e0, exp_n);
    chk(neoseq - q0 == 1, "R4 eoseq", neoseq - q0, 1);
  endtask

  initial begin
    #(4 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int s0, q0;
    logic [DW-1:0] d0;
    void'($urandom(32'd4242));
    wn(3); rst_n = 1; wn(1);
    // R1
    chk(!running && !conv_req, "R1 idle", running, 0);
    chk(!eoc && !ovr && !eoseq && !eosmp, "R1 flags", {eoc, ovr, eoseq, eosmp}, 0);
    chk(dout == 0, "R1 dout", dout, 0);
    chk(conv_pwr == 1'b1, "R1 power", conv_pwr, 1);

    // R3
    for (int c = 0; c < 8; c++) begin
      smp_code = 3'(c); #1;
      chk(conv_smp == 9'(smp_exp(c)), "R3 sample", conv_smp, smp_exp(c));
    end

    // R2 directed edges then random
    run_single(19'h40001, 0);
    run_single(19'h40001, 1);
    for (int it = 0; it < 20; it++) begin
      logic [NCH-1:0] m;
      m = NCH'($urandom);
      if (m == 0) m = 19'h00100;
      run_single(m, 1'($urandom));
    end

    // R4 trigger after end starts nothing
    s0 = nseen;
    p_trig(); wn(12);
    chk(!conv_req && nseen == s0, "R4 no restart", nseen - s0, 0);

    // R5 continuous
    cfg(19'h00222, 0, 1, 0, 0, 0, 1);
    build_exp(19'h00222, 0);
    s0 = nseen; q0 = neoseq;
    p_start(); p_trig();
    for (int i = 0; i < 300 && nseen - s0 < 7; i++) @(negedge clk);
    wn(2);
    chk(running == 1'b1, "R5 running", running, 1);
    chk(neoseq - q0 >= 2, "R5 eoseq count", neoseq - q0, 2);
    for (int k = 0; k < 7; k++)
      chk(int'(seen[(s0 + k) & 1023]) == exp_ch[k % 3], "R5 relaunch", int'(seen[(s0 + k) & 1023]), exp_ch[k % 3]);
    p_stop();
    chk(!running, "R10 stop cont", running, 0);

    // R6 cont + disc
    cfg(19'h00048, 0, 1, 1, 0, 0, 1);
    s0 = nseen;
    p_start(); p_trig(); wn(15);
    chk(nseen - s0 == 1 && running && !conv_req, "R6 one per trig", nseen - s0, 1);
    p_trig(); wn(15);
    chk(nseen - s0 == 2 && !running, "R6 no relaunch", running, 0);
    p_trig(); wn(12);
    chk(nseen - s0 == 2, "R6 ended", nseen - s0, 2);

    // R7 discontinuous, descending
    cfg(19'h40401, 1, 0, 1, 0, 0, 1);
    s0 = nseen;
    p_start();
    p_trig(); wn(15);
    chk(nseen - s0 == 1 && int'(seen[s0 & 1023]) == 18, "R7 first", int'(seen[s0 & 1023]), 18);
    p_trig(); wn(15);
    chk(nseen - s0 == 2 && int'(seen[(s0 + 1) & 1023]) == 10, "R7 second", int'(seen[(s0 + 1) & 1023]), 10);
    p_trig(); wn(15);
    chk(nseen - s0 == 3 && int'(seen[(s0 + 2) & 1023]) == 0 && !running, "R7 last", int'(seen[(s0 + 2) & 1023]), 0);

    // R8 / R11 wait mode with auto power-off
    cfg(19'h00084, 0, 0, 0, 1, 1, 1);
    s0 = nseen;
    p_start();
    chk(conv_pwr == 1'b0, "R11 off while armed", conv_pwr, 0);
    p_trig();
    chk(conv_pwr == 1'b1, "R11 on while converting", conv_pwr, 1);
    for (int i = 0; i < 50 && !eoc; i++) @(negedge clk);
    wn(15);
    chk(!conv_req && nseen - s0 == 1, "R8 hold", nseen - s0, 1);
    chk(conv_pwr == 1'b0, "R11 off in wait", conv_pwr, 0);
    p_trig(); wn(5);
    chk(!conv_req, "R9 trig in wait", conv_req, 0);
    p_rd();
    chk(conv_req == 1'b1 && conv_ch == 5'd7, "R8 resume", conv_ch, 7);
    wait_idle(); wn(12);
    chk(nseen - s0 == 2 && !running, "R9 not queued", nseen - s0, 2);
    chk(conv_pwr == 1'b0, "R11 off idle", conv_pwr, 0);

    // R9 trigger during conversion
    cfg(19'h00010, 0, 0, 0, 0, 0, 1);
    s0 = nseen;
    p_start(); p_trig(); p_trig();
    wait_idle(); wn(12);
    chk(nseen - s0 == 1 && !conv_req, "R9 trig in conv", nseen - s0, 1);

    // R10 stop mid conversion
    cfg(19'h00020, 0, 0, 0, 0, 0, 1);
    d0 = dout; s0 = nseen;
    p_start(); p_trig(); wn(2); p_stop();
    chk(!conv_req && !running, "R10 abort", conv_req, 0);
    wn(12);
    chk(dout == d0 && !eoc && nseen == s0, "R10 data kept", dout, d0);

    // R12 keep old / R13 eoc
    cfg(19'h00110, 0, 0, 0, 0, 0, 0);
    p_start(); p_trig(); wait_idle(); wn(2);
    chk(dout == dfun(5'd4), "R12 keep old", dout, dfun(5'd4));
    chk(ovr == 1'b1, "R12 set", ovr, 1);
    chk(eoc == 1'b1, "R13 eoc set", eoc, 1);
    p_oclr();
    chk(ovr == 1'b0, "R12 clear", ovr, 0);
    p_rd();
    chk(eoc == 1'b0, "R13 eoc clear", eoc, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule